// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block merges every interrupt source of a PCIe root port into one interrupt line for the host CPU. It takes four legacy INTx wires (A to D) and a stream of MSI write events. The MSI write events arrive already decoded, each as a valid strobe plus the data word of the write. Software reaches the block through a small register slave with single-cycle read and write strobes. Through it, software sees one local pending word, sets one local enable word, reads the fixed MSI target address that endpoints are told to write to, and services a 32-entry MSI vector word.

The four INTx sources behave as levels. Their pending bits are sampled every cycle, so clearing one while its wire is still high only lets it come back on the next cycle. MSI events are pulses. Each accepted event sets one sticky bit in the vector word, and only a write-one-to-clear removes it. A single summary bit in the local pending word stands for the whole vector word. The CPU line is a registered OR over the pending bits that are enabled. After reset every source is disabled.

Top module: `pcie_irq_aggr`

## Requirements
- R1: After reset the enable word, the local pending word and the MSI vector word all read 0, and `cpu_irq` is 0.
- R2: The enable word sits at offset 0x180. Only bits 24 to 28 are stored, and they read back as written. All other bits read 0. The word changes only when it is written.
- R3: Local pending bits 24, 25, 26 and 27 belong to INTx A, B, C and D. One cycle after a wire is sampled high, its bit is 1. If a write-one-to-clear hits the bit while the wire is still high, the bit reads 1 again afterwards.
- R4: Writing 1s to the local pending word at offset 0x184 clears those bits. Writing 0xFFFFFFFF clears every INTx bit whose wire is low.
- R5: An MSI event whose data value v is in the range 0 to 31 sets bit v of the MSI vector word at offset 0x194 in the next cycle. Writing 1s to that word clears the matching bits and no others.
- R6: An MSI event whose data value is 32 or more leaves the MSI vector word unchanged.
- R7: Bit 28 of the local pending word is 1 whenever any MSI vector bit is 1, and it survives a write-one-to-clear in that case. Once the vector word is empty, a write-one-to-clear removes it. A later MSI event sets it again.
- R8: Offset 0x190 reads the MSI target address parameter. Writes to it have no effect.
- R9: `cpu_irq` equals the OR of (local pending AND enable), taken one cycle earlier. A pending source that is not enabled never raises it.
- R10: When a set event and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up 1.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| intx_lvl | input | 4 | INTx A..D levels, bit 0 = A |
| msi_valid | input | 1 | One-cycle MSI write event |
| msi_data | input | MSI_DATA_W | Data word of the MSI write (vector number) |
| cpu_irq | output | 1 | Registered interrupt to the host CPU |

## Verification
The bench builds the block with 32 vectors, a 16-bit MSI data word and a target address of 0xFEE01000. Because the data word is wider than the vector index, events with data 32 and 40 can be sent, and the bench can check that they are dropped rather than aliased onto vectors 0 and 8. The full 32 vectors bring the top vector (31) and the highest read-data bit within reach. The non-default address shows that the target-address register returns the parameter and not a constant.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int ADDR_W   = 12;
  localparam int REG_W    = 32;
  localparam int INTX_N   = 4;
  localparam int SRC_N    = INTX_N + 1;
  localparam int INTX_LSB = 24;
  localparam int SUM_BIT  = INTX_LSB + INTX_N;

  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 12'h184;
  localparam logic [ADDR_W-1:0] OFS_MSIADR  = 12'h190;
  localparam logic [ADDR_W-1:0] OFS_MSIVEC  = 12'h194;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_PEND,
    SEL_MSIADR,
    SEL_MSIVEC
  } regsel_e;

  function automatic regsel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_ENABLE: decode_ofs = SEL_ENABLE;
      OFS_PEND:   decode_ofs = SEL_PEND;
      OFS_MSIADR: decode_ofs = SEL_MSIADR;
      OFS_MSIVEC: decode_ofs = SEL_MSIVEC;
      default:    decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqagg_intx_lat.sv
module irqagg_intx_lat #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic d;
    logic en;
    logic q;

    always_comb begin
      en = lvl[i] | clr[i];
      d  = (q & ~clr[i]) | lvl[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
      end else if (en) begin
        q <= d;
      end
    end

    assign pend[i] = q;
  end
endmodule

// File: rtl/irqagg_msi_vec.sv
module irqagg_msi_vec #(
  parameter int NUM_VEC = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [DATA_W-1:0]  evt_data,
  input  logic [NUM_VEC-1:0] clr,
  input  logic               sum_clr,
  output logic [NUM_VEC-1:0] vec_pend,
  output logic               sum_pend
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam logic [DATA_W-1:0] LIM = DATA_W'(NUM_VEC);

  logic               hit;
  logic [NUM_VEC-1:0] set;
  logic               sum_d;
  logic               sum_en;
  logic               sum_q;

  always_comb begin
    hit = evt_valid && (evt_data < LIM);
    set = hit ? (NUM_VEC'(1) << evt_data[VEC_W-1:0]) : '0;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic d;
    logic en;
    logic q;

    always_comb begin
      en = set[v] | clr[v];
      d  = (q & ~clr[v]) | set[v];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
      end else if (en) begin
        q <= d;
      end
    end

    assign vec_pend[v] = q;
  end

  always_comb begin
    sum_en = sum_clr | hit | (|vec_pend);
    sum_d  = (sum_q & ~sum_clr) | hit | (|vec_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= 1'b0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum_pend = sum_q;
endmodule

// File: rtl/irqagg_enable.sv
module irqagg_enable #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  logic [W-1:0] d;

  always_comb d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we) begin
      en_q <= d;
    end
  end
endmodule

// File: rtl/pcie_irq_aggr.sv
module pcie_irq_aggr
  import irqagg_pkg::*;
#(
  parameter int          NUM_VEC    = 32,
  parameter int          MSI_DATA_W = 16,
  parameter logic [31:0] MSI_TARGET = 32'hFEE0_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [INTX_N-1:0]     intx_lvl,
  input  logic                  msi_valid,
  input  logic [MSI_DATA_W-1:0] msi_data,
  output logic                  cpu_irq
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[1];

  // Decode
  regsel_e            sel;
  logic               wr_enable;
  logic               wr_pend;
  logic               wr_msivec;
  logic [INTX_N-1:0]  intx_clr;
  logic               sum_clr;
  logic [NUM_VEC-1:0] vec_clr;

  always_comb begin
    sel       = decode_ofs(reg_addr);
    wr_enable = reg_wr && (sel == SEL_ENABLE);
    wr_pend   = reg_wr && (sel == SEL_PEND);
    wr_msivec = reg_wr && (sel == SEL_MSIVEC);
    intx_clr  = wr_pend ? reg_wdata[SUM_BIT-1:INTX_LSB] : '0;
    sum_clr   = wr_pend & reg_wdata[SUM_BIT];
    vec_clr   = wr_msivec ? reg_wdata[NUM_VEC-1:0] : '0;
  end

  // Sources
  logic [INTX_N-1:0]  intx_pend;
  logic [NUM_VEC-1:0] vec_pend;
  logic               sum_pend;
  logic [SRC_N-1:0]   src;
  logic [SRC_N-1:0]   en_q;

  irqagg_intx_lat #(.N(INTX_N)) u_intx (
    .clk   (clk),
    .rst_n (rst_n_int),
    .lvl   (intx_lvl),
    .clr   (intx_clr),
    .pend  (intx_pend)
  );

  irqagg_msi_vec #(.NUM_VEC(NUM_VEC), .DATA_W(MSI_DATA_W)) u_msi (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .evt_valid (msi_valid),
    .evt_data  (msi_data),
    .clr       (vec_clr),
    .sum_clr   (sum_clr),
    .vec_pend  (vec_pend),
    .sum_pend  (sum_pend)
  );

  irqagg_enable #(.W(SRC_N)) u_en (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (wr_enable),
    .wdata (reg_wdata[SUM_BIT:INTX_LSB]),
    .en_q  (en_q)
  );

  assign src = {sum_pend, intx_pend};

  // Read path
  logic [REG_W-1:0] rdata_d;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    case (sel)
      SEL_ENABLE: rdata_d = REG_W'(en_q) << INTX_LSB;
      SEL_PEND:   rdata_d = REG_W'(src) << INTX_LSB;
      SEL_MSIADR: rdata_d = MSI_TARGET;
      SEL_MSIVEC: rdata_d = REG_W'(vec_pend);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rdata_d;
    end
  end
  assign reg_rdata = rdata_q;

  // CPU line
  logic irq_d;
  logic irq_q;

  always_comb irq_d = |(src & en_q);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end
  assign cpu_irq = irq_q;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int NUM_VEC    = 32,
  parameter int MSI_DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            intx_lvl,
  input logic [3:0]            intx_pend,
  input logic                  msi_valid,
  input logic [MSI_DATA_W-1:0] msi_data,
  input logic [NUM_VEC-1:0]    vec_pend,
  input logic                  sum_pend,
  input logic                  wr_msivec,
  input logic                  wr_enable,
  input logic [4:0]            src,
  input logic [4:0]            en_q,
  input logic                  cpu_irq
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam logic [MSI_DATA_W-1:0] LIM = MSI_DATA_W'(NUM_VEC);

  AST_INTX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|intx_lvl) |=> ((intx_pend & $past(intx_lvl)) == $past(intx_lvl))); // R3

  AST_MSI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && (msi_data < LIM)) |=> vec_pend[$past(msi_data[VEC_W-1:0])]); // R10

  AST_MSI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && (msi_data >= LIM) && !wr_msivec) |=> (vec_pend == $past(vec_pend))); // R6

  AST_SUM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|vec_pend) |=> sum_pend); // R7

  AST_IRQ_REG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(|(src & en_q)))); // R9

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(en_q)); // R2
endmodule

bind pcie_irq_aggr irqagg_chk #(.NUM_VEC(NUM_VEC), .MSI_DATA_W(MSI_DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .intx_lvl  (intx_lvl),
  .intx_pend (intx_pend),
  .msi_valid (msi_valid),
  .msi_data  (msi_data),
  .vec_pend  (vec_pend),
  .sum_pend  (sum_pend),
  .wr_msivec (wr_msivec),
  .wr_enable (wr_enable),
  .src       (src),
  .en_q      (en_q),
  .cpu_irq   (cpu_irq)
);

// File: tb/pcie_irq_aggr_bench.sv
module pcie_irq_aggr_bench;
  localparam int          NV  = 32;
  localparam int          DW  = 16;
  localparam logic [31:0] TGT = 32'hFEE0_1000;

  localparam logic [11:0] A_EN   = 12'h180;
  localparam logic [11:0] A_PEND = 12'h184;
  localparam logic [11:0] A_ADR  = 12'h190;
  localparam logic [11:0] A_VEC  = 12'h194;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic          reg_rd;
  logic [11:0]   reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [3:0]    intx_lvl;
  logic          msi_valid;
  logic [DW-1:0] msi_data;
  logic          cpu_irq;

  always #5 clk = ~clk;

  pcie_irq_aggr #(.NUM_VEC(NV), .MSI_DATA_W(DW), .MSI_TARGET(TGT)) u_pcie_irq_aggr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .intx_lvl  (intx_lvl),
    .msi_valid (msi_valid),
    .msi_data  (msi_data),
    .cpu_irq   (cpu_irq)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: read data is valid in the cycle after the strobe.
  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        compare("R11 unexpected read", reg_rdata, 32'h0);
      end else begin
        compare(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic msi_send(input logic [DW-1:0] v);
    @(negedge clk);
    msi_valid = 1'b1; msi_data = v;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    intx_lvl = '0; msi_valid = 1'b0; msi_data = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    compare("R1 cpu_irq after reset", {31'h0, cpu_irq}, 32'h0);
    do_rd(A_EN,   32'h0, "R1 enable reset");
    do_rd(A_PEND, 32'h0, "R1 pending reset");
    do_rd(A_VEC,  32'h0, "R1 vector reset");

    do_wr(A_EN, 32'hFFFF_FFFF);
    do_rd(A_EN, 32'h1F00_0000, "R2 enable readback");

    do_rd(A_ADR, TGT, "R8 target address");
    do_wr(A_ADR, 32'h0);
    do_rd(A_ADR, TGT, "R8 write ignored");

    // INTB level, all enabled
    intx_lvl = 4'b0010;
    idle(3);
    compare("R9 irq from INTB", {31'h0, cpu_irq}, 32'h1);
    do_rd(A_PEND, 32'h0200_0000, "R3 INTB pending");
    do_wr(A_PEND, 32'h0200_0000);
    do_rd(A_PEND, 32'h0200_0000, "R3 relatch while high");
    intx_lvl = 4'b0000;
    do_wr(A_PEND, 32'hFFFF_FFFF);
    do_rd(A_PEND, 32'h0, "R4 clear all");
    idle(2);
    compare("R9 irq drops", {31'h0, cpu_irq}, 32'h0);

    // Masked INTA
    do_wr(A_EN, 32'h0);
    intx_lvl = 4'b0001;
    idle(3);
    compare("R9 masked source", {31'h0, cpu_irq}, 32'h0);
    do_rd(A_PEND, 32'h0100_0000, "R3 INTA pending");
    do_wr(A_EN, 32'h0100_0000);
    idle(2);
    compare("R9 unmasked source", {31'h0, cpu_irq}, 32'h1);
    intx_lvl = 4'b0000;
    do_wr(A_PEND, 32'hFFFF_FFFF);
    idle(2);
    compare("R4 irq after clear", {31'h0, cpu_irq}, 32'h0);

    // MSI
    do_wr(A_EN, 32'h1000_0000);
    msi_send(DW'(5));
    msi_send(DW'(31));
    do_rd(A_VEC, 32'h8000_0020, "R5 vectors 5 and 31");
    do_rd(A_PEND, 32'h1000_0000, "R7 summary set");
    compare("R9 irq from summary", {31'h0, cpu_irq}, 32'h1);
    msi_send(DW'(32));
    msi_send(DW'(40));
    do_rd(A_VEC, 32'h8000_0020, "R6 out-of-range ignored");
    do_wr(A_VEC, 32'h0000_0020);
    do_rd(A_VEC, 32'h8000_0000, "R5 w1c one vector");
    do_wr(A_PEND, 32'h1000_0000);
    do_rd(A_PEND, 32'h1000_0000, "R7 summary held");
    do_wr(A_VEC, 32'hFFFF_FFFF);
    do_wr(A_PEND, 32'h1000_0000);
    do_rd(A_PEND, 32'h0, "R7 summary cleared");
    do_rd(A_VEC, 32'h0, "R5 vector word empty");
    idle(2);
    compare("R9 irq idle", {31'h0, cpu_irq}, 32'h0);
    msi_send(DW'(0));
    do_rd(A_PEND, 32'h1000_0000, "R7 summary re-asserts");

    // Set beats clear in the same cycle
    do_wr(A_VEC, 32'hFFFF_FFFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_VEC; reg_wdata = 32'h0000_0080;
    msi_valid = 1'b1; msi_data = DW'(7);
    @(negedge clk);
    reg_wr = 1'b0; msi_valid = 1'b0;
    do_rd(A_VEC, 32'h0000_0080, "R10 set wins");

    do_rd(12'h000, 32'h0, "R11 unmapped 0x000");
    do_rd(12'h188, 32'h0, "R11 unmapped 0x188");

    idle(3);
    if (exp_q.size() != 0) compare("R11 reads outstanding", 32'(exp_q.size()), 32'h0);
    summary();
    $finish;
  end
endmodule